// File: doc/BRIEF.md
# General-Purpose Pin Bank with Interrupt Detection

This block controls one bank of general-purpose pins through a plain 32-bit register bus. The bus has an address, a write strobe, write data and registered read data.

- **Pin control.** Each pin has an output-enable bit and an output-data bit. The pin drives its output-data value only while its output-enable bit is set. Pin inputs pass through a two-stage synchronizer before software can read them.
- **Interrupt detection.** Each pin has its own interrupt detector. Three per-pin configuration words choose the detection mode:
  - a sense word selects level or edge sensing;
  - a polarity word selects high/rising or low/falling;
  - a both-edges word makes the pin fire on every transition.
- **Status and the interrupt line.** Detected events collect in a raw status word. A per-pin enable mask gates them into a masked status word. The OR of the masked bits drives a single registered interrupt line.
- **Acknowledge.** Software acknowledges an edge event by writing ones to a write-one-to-clear word.

A chip places several copies of this bank at a 0x200-byte stride. Each copy decodes only the low nine address bits of its bank window. Every register holds one bit per pin, and pin n uses bit n.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is high and on the first cycle after it, every register reads zero, `pin_oe`, `pin_out` and `irq` are zero, and `bus_rdata` is zero.
- R2: Writes to offset 0x04 (output data) and 0x08 (output enable) appear on `pin_out` and `pin_oe` after the write edge, and read back unchanged. Writes to offsets 0x0C (sense: 1 = level, 0 = edge), 0x10 (both edges), 0x14 (polarity: 1 = high/rising, 0 = low/falling) and 0x18 (enable mask: 1 = enabled) read back unchanged.
- R3: Offset 0x00 returns the pin inputs after a two-flop synchronizer. A read issued in the same cycle that a pin changes returns the old value.
- R4: In edge mode with the both-edges bit at 0, a pin sets its raw status bit (offset 0x1C) only on a rising edge when polarity is 1, and only on a falling edge when polarity is 0.
- R5: With the both-edges bit at 1, a pin in edge mode sets its raw status bit on rising and on falling edges, whatever its polarity bit holds.
- R6: In level mode, the raw status bit follows the synchronized pin level: the level itself when polarity is 1, the inverted level when polarity is 0. A clear write does not remove a level that is still active.
- R7: An edge status bit stays set until a 1 is written to that bit at offset 0x24. Writing a 0 there leaves it set.
- R8: When an edge is detected in the same cycle as a clear write to that bit, the bit remains set.
- R9: Offset 0x20 reads raw status AND enable mask. `irq` is the OR of that word, delayed by one register.
- R10: Writes to offsets 0x00, 0x1C and 0x20 have no effect. Offset 0x24 and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Byte offset within the bank window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the address |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output data per pin |
| pin_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Combined interrupt line, registered |

## Verification
The bench aims at each of these corner cases:

- **Synchronizer latency.** A read issued as a pin changes must still return the old value. A design missing a stage returns the new value early.
- **Polarity and both-edges selection.** Opposite-direction edges on neighbouring pins must be ignored. A design that ignores polarity, or lets polarity override the both-edges bit, latches the wrong pins.
- **Level mode under a clear write.** A clear write in level mode must not drop an active level. A design that lets the clear win briefly reports no interrupt.
- **Edge arriving with a clear.** An edge timed to land on the very edge of a clear write must stay recorded. A design that gives the clear priority loses the event.
- **Read-only words and the mask.** Writes to the read-only words must leave them unchanged. Toggling the mask must gate `irq` without touching raw status.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Byte offsets inside one bank window (software-visible, kept fixed).
  localparam int unsigned OFS_DIN   = 'h00;
  localparam int unsigned OFS_DOUT  = 'h04;
  localparam int unsigned OFS_OE    = 'h08;
  localparam int unsigned OFS_SENSE = 'h0C;
  localparam int unsigned OFS_BOTH  = 'h10;
  localparam int unsigned OFS_POL   = 'h14;
  localparam int unsigned OFS_MASK  = 'h18;
  localparam int unsigned OFS_RAW   = 'h1C;
  localparam int unsigned OFS_MSTS  = 'h20;
  localparam int unsigned OFS_CLR   = 'h24;

  typedef enum logic [3:0] {
    SEL_DIN, SEL_DOUT, SEL_OE, SEL_SENSE, SEL_BOTH,
    SEL_POL, SEL_MASK, SEL_RAW, SEL_MSTS, SEL_CLR, SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out,
  output logic [WIDTH-1:0] prev_out
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= raw_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  // One more flop holds last cycle's synchronized value for edge compare.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stage_q[STAGES-1];
  end

  assign sync_out = stage_q[STAGES-1];
  assign prev_out = prev_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] level_now,
  input  logic [NPINS-1:0] level_prev,
  input  logic [NPINS-1:0] cfg_level,
  input  logic [NPINS-1:0] cfg_both,
  input  logic [NPINS-1:0] cfg_pol,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] edge_hit,
  output logic [NPINS-1:0] status
);

  genvar i;
  generate
    for (i = 0; i < NPINS; i++) begin : g_pin
      logic rise, fall, lvl_act, sts_q;

      assign rise    = level_now[i] & ~level_prev[i];
      assign fall    = ~level_now[i] & level_prev[i];
      assign lvl_act = cfg_pol[i] ? level_now[i] : ~level_now[i];

      always_comb begin
        if (cfg_both[i])     edge_hit[i] = rise | fall;
        else if (cfg_pol[i]) edge_hit[i] = rise;
        else                 edge_hit[i] = fall;
      end

      // Level pins track the pin; edge pins latch, new edge beats clear.
      always_ff @(posedge clk) begin
        if (rst)               sts_q <= 1'b0;
        else if (cfg_level[i]) sts_q <= lvl_act;
        else                   sts_q <= edge_hit[i] | (sts_q & ~clr_mask[i]);
      end

      assign status[i] = sts_q;
    end
  endgenerate

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  din,
  input  logic [NPINS-1:0]  raw_sts,
  output logic [NPINS-1:0]  dout,
  output logic [NPINS-1:0]  oe,
  output logic [NPINS-1:0]  sense,
  output logic [NPINS-1:0]  both,
  output logic [NPINS-1:0]  pol,
  output logic [NPINS-1:0]  mask,
  output logic [NPINS-1:0]  clr
);

  reg_sel_e sel;
  logic [NPINS-1:0] wbits;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    if      (bus_addr == ADDR_W'(OFS_DIN))   sel = SEL_DIN;
    else if (bus_addr == ADDR_W'(OFS_DOUT))  sel = SEL_DOUT;
    else if (bus_addr == ADDR_W'(OFS_OE))    sel = SEL_OE;
    else if (bus_addr == ADDR_W'(OFS_SENSE)) sel = SEL_SENSE;
    else if (bus_addr == ADDR_W'(OFS_BOTH))  sel = SEL_BOTH;
    else if (bus_addr == ADDR_W'(OFS_POL))   sel = SEL_POL;
    else if (bus_addr == ADDR_W'(OFS_MASK))  sel = SEL_MASK;
    else if (bus_addr == ADDR_W'(OFS_RAW))   sel = SEL_RAW;
    else if (bus_addr == ADDR_W'(OFS_MSTS))  sel = SEL_MSTS;
    else if (bus_addr == ADDR_W'(OFS_CLR))   sel = SEL_CLR;
    else                                     sel = SEL_NONE;
  end

  assign wbits = bus_wdata[NPINS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      oe    <= '0;
      sense <= '0;
      both  <= '0;
      pol   <= '0;
      mask  <= '0;
    end else if (bus_we) begin
      case (sel)
        SEL_DOUT:  dout  <= wbits;
        SEL_OE:    oe    <= wbits;
        SEL_SENSE: sense <= wbits;
        SEL_BOTH:  both  <= wbits;
        SEL_POL:   pol   <= wbits;
        SEL_MASK:  mask  <= wbits;
        default:   ;
      endcase
    end
  end

  assign clr = (bus_we && sel == SEL_CLR) ? wbits : '0;

  always_comb begin
    case (sel)
      SEL_DIN:   rd_next = DATA_W'(din);
      SEL_DOUT:  rd_next = DATA_W'(dout);
      SEL_OE:    rd_next = DATA_W'(oe);
      SEL_SENSE: rd_next = DATA_W'(sense);
      SEL_BOTH:  rd_next = DATA_W'(both);
      SEL_POL:   rd_next = DATA_W'(pol);
      SEL_MASK:  rd_next = DATA_W'(mask);
      SEL_RAW:   rd_next = DATA_W'(raw_sts);
      SEL_MSTS:  rd_next = DATA_W'(raw_sts & mask);
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  logic [NPINS-1:0] sync_q, prev_q;
  logic [NPINS-1:0] sts_q, edge_vec;
  logic [NPINS-1:0] type_q, both_q, pol_q, mask_q, clr_vec;
  logic             irq_q;

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .raw_in(pin_in),
    .sync_out(sync_q), .prev_out(prev_q)
  );

  gpio_bank_regs #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .din(sync_q), .raw_sts(sts_q),
    .dout(pin_out), .oe(pin_oe),
    .sense(type_q), .both(both_q), .pol(pol_q), .mask(mask_q),
    .clr(clr_vec)
  );

  gpio_irq_detect #(.NPINS(NPINS)) det_i (
    .clk(clk), .rst(rst),
    .level_now(sync_q), .level_prev(prev_q),
    .cfg_level(type_q), .cfg_both(both_q), .cfg_pol(pol_q),
    .clr_mask(clr_vec),
    .edge_hit(edge_vec), .status(sts_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(sts_q & mask_q);
  end

  assign irq = irq_q;

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPINS  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  sts_q,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  type_q,
  input logic [NPINS-1:0]  pol_q,
  input logic [NPINS-1:0]  sync_q,
  input logic [NPINS-1:0]  edge_vec
);

  // R1: reset leaves outputs quiet on the following cycle
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && irq == 1'b0 && bus_rdata == '0));

  // R2: output-enable write reaches the pins on the next cycle
  a_r2_oe_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'('h08)) |=> (pin_oe == $past(bus_wdata[NPINS-1:0])));

  // R6: level pins mirror the synchronized level qualified by polarity
  a_r6_level_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((sts_q ^ ~($past(pol_q) ^ $past(sync_q))) & $past(type_q)) == '0));

  // R7: an edge-mode status bit only rises when an edge was seen
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(type_q) & ~$past(edge_vec)) == '0));

  // R8: a detected edge is never lost, even against a clear write
  a_r8_edge_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(edge_vec) & ~$past(type_q) & ~sts_q) == '0));

  // R9: the interrupt line is last cycle's OR of masked status
  a_r9_irq_or: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(sts_q) & $past(mask_q))));

  // R10: the clear word reads back as zero
  a_r10_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'('h24)) |=> (bus_rdata == '0));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_oe(pin_oe), .irq(irq),
  .sts_q(sts_q), .mask_q(mask_q), .type_q(type_q), .pol_q(pol_q),
  .sync_q(sync_q), .edge_vec(edge_vec)
);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;

  localparam logic [8:0] A_DIN = 9'h00, A_DOUT = 9'h04, A_OE = 9'h08,
    A_SENSE = 9'h0C, A_BOTH = 9'h10, A_POL = 9'h14, A_MASK = 9'h18,
    A_RAW = 9'h1C, A_MSTS = 9'h20, A_CLR = 9'h24, A_GAP = 9'h28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_irq_bank dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  typedef struct packed {
    logic [8:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  // Write-then-read vectors: R10 read-only/unmapped first, then R2 config words.
  localparam vec_t VECS [12] = '{
    '{A_RAW,   32'hFFFF_FFFF, 32'h0,          4'd10},
    '{A_MSTS,  32'hFFFF_FFFF, 32'h0,          4'd10},
    '{A_CLR,   32'hFFFF_FFFF, 32'h0,          4'd10},
    '{A_DIN,   32'hDEAD_BEEF, 32'h0,          4'd10},
    '{A_GAP,   32'h1234_5678, 32'h0,          4'd10},
    '{A_DOUT,  32'hA5A5_0F0F, 32'hA5A5_0F0F,  4'd2},
    '{A_OE,    32'hFFFF_0000, 32'hFFFF_0000,  4'd2},
    '{A_SENSE, 32'h0F0F_0F0F, 32'h0F0F_0F0F,  4'd2},
    '{A_BOTH,  32'h3333_CCCC, 32'h3333_CCCC,  4'd2},
    '{A_POL,   32'h8000_0001, 32'h8000_0001,  4'd2},
    '{A_MASK,  32'h0000_0000, 32'h0000_0000,  4'd2},
    '{A_MASK,  32'h5A5A_5A5A, 32'h5A5A_5A5A,  4'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic pins(input logic [31:0] p, input int wait_cyc);
    @(negedge clk);
    pin_in = p;
    repeat (wait_cyc) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: state during and right after reset
    chk("R1 pin_oe in reset", pin_oe, 32'h0);
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    rst = 1'b0;
    chk("R1 pin_out after reset", pin_out, 32'h0);
    rd(A_MASK, v);  chk("R1 mask reset", v, 32'h0);
    rd(A_SENSE, v); chk("R1 sense reset", v, 32'h0);

    // Vector table: R2 readback, R10 ignored writes
    for (int k = 0; k < 12; k++) begin
      wr(VECS[k].addr, VECS[k].wdata);
      rd(VECS[k].addr, v);
      chk($sformatf("R%0d vec%0d", VECS[k].req, k), v, VECS[k].expv);
    end
    chk("R2 pin_out port", pin_out, 32'hA5A5_0F0F);
    chk("R2 pin_oe port", pin_oe, 32'hFFFF_0000);

    // Return to a clean state
    wr(A_DOUT, 0); wr(A_OE, 0); wr(A_SENSE, 0); wr(A_BOTH, 0);
    wr(A_POL, 0); wr(A_MASK, 0); wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_RAW, v); chk("R7 clean start", v, 32'h0);

    // R3: synchronizer latency, then settled value
    @(negedge clk);
    pin_in = 32'h1234_5678; bus_addr = A_DIN; bus_we = 1'b0;
    @(negedge clk);
    chk("R3 old value on change", bus_rdata, 32'h0);
    repeat (3) @(negedge clk);
    rd(A_DIN, v); chk("R3 settled input", v, 32'h1234_5678);
    wr(A_DIN, 32'hFFFF_FFFF);
    rd(A_DIN, v); chk("R10 din write ignored", v, 32'h1234_5678);
    rd(A_RAW, v); chk("R4 rising ignored at pol0", v, 32'h0);

    // R4: falling edges latch with polarity 0
    pins(32'h0, 4);
    rd(A_RAW, v); chk("R4 falling latched", v, 32'h1234_5678);
    wr(A_CLR, 32'hFFFF_FFFF);

    // R4: rising with polarity 1 on bit0, bit8 stays falling
    wr(A_POL, 32'h0000_00FF);
    wr(A_MASK, 32'hFFFF_FFFF);
    pins(32'h0000_0101, 4);
    rd(A_RAW, v); chk("R4 rising pol1 only", v, 32'h1);
    chk("R9 irq high", {31'h0, irq}, 32'h1);
    rd(A_MSTS, v); chk("R9 masked", v, 32'h1);

    // R7: zero write keeps, one write clears
    wr(A_CLR, 32'h0);
    rd(A_RAW, v); chk("R7 zero write no effect", v, 32'h1);
    wr(A_CLR, 32'h1);
    @(negedge clk);
    chk("R9 irq drops after clear", {31'h0, irq}, 32'h0);
    rd(A_RAW, v); chk("R7 cleared", v, 32'h0);

    pins(32'h0, 4);
    rd(A_RAW, v); chk("R4 falling bit8 not bit0", v, 32'h100);
    wr(A_CLR, 32'h100);

    // R5: both edges regardless of polarity
    wr(A_BOTH, 32'h0001_0000);
    pins(32'h0001_0000, 4);
    rd(A_RAW, v); chk("R5 rise on both-edge pin", v, 32'h0001_0000);
    wr(A_CLR, 32'h0001_0000);
    pins(32'h0, 4);
    rd(A_RAW, v); chk("R5 fall on both-edge pin", v, 32'h0001_0000);
    wr(A_CLR, 32'h0001_0000);

    // R9: mask gates irq without touching raw
    pins(32'h0001_0000, 4);
    wr(A_MASK, 32'h1);
    repeat (2) @(negedge clk);
    chk("R9 irq masked off", {31'h0, irq}, 32'h0);
    rd(A_MSTS, v); chk("R9 masked word zero", v, 32'h0);
    rd(A_RAW, v); chk("R9 raw kept", v, 32'h0001_0000);
    wr(A_MASK, 32'h0001_0000);
    repeat (2) @(negedge clk);
    chk("R9 irq unmasked", {31'h0, irq}, 32'h1);
    wr(A_CLR, 32'h0001_0000);

    // R6: level mode, active high on bit4
    wr(A_SENSE, 32'h0000_0010);
    rd(A_RAW, v); chk("R6 inactive level", v, 32'h0);
    pins(32'h0001_0010, 4);
    rd(A_RAW, v); chk("R6 active high", v, 32'h10);
    wr(A_CLR, 32'h10);
    rd(A_RAW, v); chk("R6 clear does not hide level", v, 32'h10);
    pins(32'h0001_0000, 4);
    rd(A_RAW, v); chk("R6 level released", v, 32'h0);
    // R6: active low on bit20 (polarity 0, pin low)
    wr(A_SENSE, 32'h0010_0010);
    @(negedge clk);
    rd(A_RAW, v); chk("R6 active low", v, 32'h0010_0000);
    pins(32'h0011_0000, 4);
    rd(A_RAW, v); chk("R6 active low released", v, 32'h0);
    wr(A_SENSE, 32'h0);

    // R8: rising edge on bit0 lands on the clear write edge
    @(negedge clk); pin_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = A_CLR; bus_we = 1'b1; bus_wdata = 32'h1;
    @(negedge clk); bus_we = 1'b0;
    rd(A_RAW, v); chk("R8 edge wins over clear", v, 32'h1);

    // R1: mid-run reset
    wr(A_OE, 32'h0000_F0F0); wr(A_DOUT, 32'h3);
    chk("R2 oe before reset", pin_oe, 32'h0000_F0F0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 oe cleared", pin_oe, 32'h0);
    chk("R1 dout cleared", pin_out, 32'h0);
    chk("R1 irq cleared", {31'h0, irq}, 32'h0);
    rd(A_POL, v); chk("R1 polarity cleared", v, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule